// File: doc/BRIEF.md
# Power-of-Two Weight Shift MAC

This block forms the dot product of one neuron without using a multiplier. Every weight arrives as a 4-bit code that stands for zero or for a signed power of two between 2^-6 and 2^0. Each activation is turned into its product term by an arithmetic right shift and a conditional negate, and the terms are summed in a wide internal accumulator.

Pairs of (activation, weight code) stream in one per clock with a valid/ready handshake. A start strobe on a pair opens a new sum with that pair, and a last strobe closes it. One cycle after the last pair is accepted, the saturated 16-bit sum appears on `res_data` together with a single-cycle `res_valid` strobe. The input side never applies back-pressure: `in_ready` is held high, so a pair is taken on every clock edge where `in_valid` is high. The result side has no ready input. The consumer must take the result in the cycle `res_valid` is high. `res_data` then keeps that value until the next result is presented.

Activations and results are signed 16-bit fixed-point numbers with 4 fractional bits. A typical use is to feed one neuron's weights and the previous layer's outputs in lock-step from local memories.

Top module: `pow2_shift_mac`

## Requirements
- R1: Weight code `in_code[3]` is the sign and `in_code[2:0]` is a selector s. When s = 0 the weight is zero, whatever the sign. Otherwise the weight is +2^(s-7), or -2^(s-7) when the sign bit is 1. Code 7 is +1, code 15 is -1, code 1 is +1/64 and code 9 is -1/64.
- R2: Each product term is the activation times the weight, rounded toward negative infinity to 4 fractional bits. For example, raw activation -3 with weight +1/4 gives -1, and raw 3 with weight -1/4 gives -1.
- R3: A pair accepted with `in_start` high begins a new sum that contains that pair alone. Any partial sum left open before it is discarded.
- R4: `in_ready` is always high. A pair is accepted only on a clock edge where `in_valid` is high. Cycles with `in_valid` low leave the running sum unchanged, whatever the other inputs carry.
- R5: When a pair with `in_last` high is accepted, `res_valid` is high in the following cycle and only then. Frames may follow one another with no idle cycle between them.
- R6: The presented result saturates: a sum above 32767 reads as 32767 (0x7FFF), and a sum below -32768 reads as -32768 (0x8000).
- R7: `res_data` holds its value in every cycle where `res_valid` is low.
- R8: During and after reset, `res_valid` is 0 and `res_data` is 0.
- R9: The running sum is at least 24 bits wide. Partial sums beyond the 16-bit range do not wrap, so a frame whose final sum is back in range gives the exact result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Pair on the input is valid |
| in_ready | output | 1 | Always high; the block takes one pair per clock |
| in_start | input | 1 | This pair opens a new sum |
| in_last | input | 1 | This pair closes the sum |
| in_act | input | 16 | Signed activation, 4 fractional bits |
| in_code | input | 4 | Weight code: bit 3 is the sign, bits 2:0 select the power |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| res_data | output | 16 | Saturated signed sum, 4 fractional bits |

## Verification
The hardest condition to reach from the ports is a running sum that leaves the 16-bit range and then comes back into it. Only this shows that the internal accumulator is wider than the output rather than saturating or wrapping on every step. The stimulus table includes a frame of two full-scale positive terms followed by two full-scale negative terms, whose exact answer is -2. Other frames land far beyond either rail to exercise saturation. Directed tests cover a start that cuts off an unfinished frame, idle cycles whose data lines carry live-looking start and last strobes, frames that follow one another with no gap, and a reset in the middle of a frame.

// File: rtl/p2mac_pkg.sv
package p2mac_pkg;
  parameter int ACT_W     = 16;  // activation / result width
  parameter int FRAC_W    = 4;   // fractional bits of activation
  parameter int CODE_W    = 4;   // weight code width
  parameter int EXT_FRAC  = 6;   // extra fractional bits kept in a term
  parameter int ACC_W     = 24;  // running-sum width

  localparam int SEL_W    = CODE_W - 1;
  localparam int SH_W     = SEL_W;
  localparam int MAX_SEL  = (1 << SEL_W) - 1;
  localparam int PROD_W   = ACT_W + EXT_FRAC + 1;
  localparam int TERM_W   = PROD_W - EXT_FRAC;

  typedef struct packed {
    logic            zero;
    logic            neg;
    logic [SH_W-1:0] shamt;
  } wdec_t;
endpackage

// File: rtl/p2mac_decode.sv
module p2mac_decode
  import p2mac_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output wdec_t             dec
);
  logic [SEL_W-1:0] sel;

  always_comb begin
    sel       = code[SEL_W-1:0];
    dec.zero  = (sel == '0);
    dec.neg   = code[CODE_W-1];
    // selector MAX_SEL is a shift of zero; smaller selectors shift further
    dec.shamt = SH_W'(MAX_SEL) - sel;
  end
endmodule

// File: rtl/p2mac_term.sv
module p2mac_term
  import p2mac_pkg::*;
(
  input  logic signed [ACT_W-1:0] act,
  input  wdec_t                   dec,
  output logic signed [ACC_W-1:0] term
);
  logic signed [PROD_W-1:0] stg [SH_W+1];
  logic signed [PROD_W-1:0] signed_p;
  logic signed [TERM_W-1:0] floored;

  // activation with EXT_FRAC guard bits below and one sign bit above
  assign stg[0] = {act[ACT_W-1], act, {EXT_FRAC{1'b0}}};

  // logarithmic arithmetic right shifter, one stage per shift-amount bit
  genvar i;
  generate
    for (i = 0; i < SH_W; i++) begin : g_stage
      assign stg[i+1] = dec.shamt[i] ? (stg[i] >>> (1 << i)) : stg[i];
    end
  endgenerate

  always_comb begin
    signed_p = dec.neg ? -stg[SH_W] : stg[SH_W];
    // dropping the guard bits of a two's complement value floors it
    floored  = signed_p[PROD_W-1:EXT_FRAC];
    term     = dec.zero ? '0 : ACC_W'(floored);
  end
endmodule

// File: rtl/p2mac_accum.sv
module p2mac_accum
  import p2mac_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic                    first,
  input  logic                    final_pair,
  input  logic signed [ACC_W-1:0] term,
  output logic                    done,
  output logic signed [ACT_W-1:0] result
);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 << (ACT_W-1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

  logic signed [ACC_W-1:0] acc_q, acc_next;
  logic signed [ACT_W-1:0] sat_v;

  always_comb begin
    acc_next = first ? term : acc_q + term;
    if (acc_next > SAT_HI)      sat_v = ACT_W'(SAT_HI);
    else if (acc_next < SAT_LO) sat_v = ACT_W'(SAT_LO);
    else                        sat_v = acc_next[ACT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= take && final_pair;
      if (take) acc_q <= acc_next;
      if (take && final_pair) result <= sat_v;
    end
  end
endmodule

// File: rtl/pow2_shift_mac.sv
module pow2_shift_mac
  import p2mac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_start,
  input  logic              in_last,
  input  logic [ACT_W-1:0]  in_act,
  input  logic [CODE_W-1:0] in_code,
  output logic              res_valid,
  output logic [ACT_W-1:0]  res_data
);
  wdec_t                   dec;
  logic signed [ACC_W-1:0] term;
  logic signed [ACT_W-1:0] result;
  logic                    take;

  assign in_ready = 1'b1;
  assign take     = in_valid && in_ready;

  p2mac_decode u_dec (
    .code (in_code),
    .dec  (dec)
  );

  p2mac_term u_term (
    .act  (in_act),
    .dec  (dec),
    .term (term)
  );

  p2mac_accum u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .first      (in_start),
    .final_pair (in_last),
    .term       (term),
    .done       (res_valid),
    .result     (result)
  );

  assign res_data = result;
endmodule

// File: rtl/p2mac_checker.sv
module p2mac_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_start,
  input logic        in_last,
  input logic [15:0] in_act,
  input logic [3:0]  in_code,
  input logic        res_valid,
  input logic [15:0] res_data
);
  logic single;
  assign single = in_valid && in_start && in_last;

  p_done_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> res_valid);

  p_no_stray_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_last) |=> !res_valid);

  p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_data));

  p_zero_weight_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (single && in_code[2:0] == 3'd0) |=> (res_data == 16'd0));

  p_pos_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (single && !in_act[15] && !in_code[3]) |=> !res_data[15]);

  p_neg_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (single && !in_act[15] && in_act != 16'd0 && in_code[3] && in_code[2:0] != 3'd0)
      |=> res_data[15]);

  p_unity_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (single && in_code == 4'd7) |=> (res_data == $past(in_act)));
endmodule

bind pow2_shift_mac p2mac_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_start  (in_start),
  .in_last   (in_last),
  .in_act    (in_act),
  .in_code   (in_code),
  .res_valid (res_valid),
  .res_data  (res_data)
);

// File: tb/pow2_shift_mac_tb.sv
module pow2_shift_mac_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0;
  logic        in_ready;
  logic [15:0] in_act = '0;
  logic [3:0]  in_code = '0;
  logic        res_valid;
  logic [15:0] res_data;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pow2_shift_mac u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_start(in_start), .in_last(in_last), .in_act(in_act), .in_code(in_code),
    .res_valid(res_valid), .res_data(res_data)
  );

  // vector table: pair count, activations, codes, expected result
  localparam int NV = 12;
  localparam int    VN [NV] = '{1, 2, 1, 1, 1, 2, 3, 4, 2, 1, 4, 4};
  localparam logic [15:0] VA [NV][4] = '{
    '{16'd100,   16'd0,     16'd0,     16'd0},
    '{16'd100,   16'd100,   16'd0,     16'd0},
    '{-16'sd3,   16'd0,     16'd0,     16'd0},
    '{16'd3,     16'd0,     16'd0,     16'd0},
    '{16'd3,     16'd0,     16'd0,     16'd0},
    '{16'd1000,  16'd1000,  16'd0,     16'd0},
    '{16'd500,   -16'sd500, 16'd7,     16'd0},
    '{16'h7FFF,  16'h7FFF,  16'h7FFF,  16'h7FFF},
    '{16'h8000,  16'h8000,  16'd0,     16'd0},
    '{16'h8000,  16'd0,     16'd0,     16'd0},
    '{16'd20,    16'd20,    16'd20,    16'd20},
    '{16'h7FFF,  16'h7FFF,  16'h8000,  16'h8000}};
  localparam logic [3:0] VC [NV][4] = '{
    '{4'd7,  4'd0, 4'd0,  4'd0},
    '{4'd7,  4'd6, 4'd0,  4'd0},
    '{4'd5,  4'd0, 4'd0,  4'd0},
    '{4'd13, 4'd0, 4'd0,  4'd0},
    '{4'd5,  4'd0, 4'd0,  4'd0},
    '{4'd1,  4'd9, 4'd0,  4'd0},
    '{4'd0,  4'd8, 4'd15, 4'd0},
    '{4'd7,  4'd7, 4'd7,  4'd7},
    '{4'd7,  4'd7, 4'd0,  4'd0},
    '{4'd15, 4'd0, 4'd0,  4'd0},
    '{4'd7,  4'd6, 4'd3,  4'd11},
    '{4'd7,  4'd7, 4'd7,  4'd7}};
  localparam logic [15:0] VE [NV] = '{
    16'd100, 16'd150, 16'hFFFF, 16'hFFFF, 16'd0, 16'hFFFF,
    16'hFFF9, 16'h7FFF, 16'h8000, 16'h7FFF, 16'd29, 16'hFFFE};
  localparam string VR [NV] = '{
    "R1", "R1", "R2", "R2", "R2", "R2", "R1", "R6", "R6", "R6", "R2", "R9"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic s, input logic l,
                       input logic [15:0] a, input logic [3:0] c);
    in_valid = v; in_start = s; in_last = l; in_act = a; in_code = c;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, 16'd0, 4'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    chk("R8 valid in reset", 32'(res_valid), 0);
    chk("R8 data in reset", 32'(res_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 valid after reset", 32'(res_valid), 0);
    chk("R4 ready high", 32'(in_ready), 1);

    // table walk
    for (int v = 0; v < NV; v++) begin
      for (int p = 0; p < VN[v]; p++) begin
        drive(1'b1, p == 0, p == VN[v] - 1, VA[v][p], VC[v][p]);
        @(negedge clk);
        if (p != VN[v] - 1) chk("R5 no early done", 32'(res_valid), 0);
      end
      idle();
      chk({VR[v], " done"}, 32'(res_valid), 1);
      chk({VR[v], " value"}, 32'(res_data), 32'(VE[v]));
      @(negedge clk);
      chk("R5 single cycle", 32'(res_valid), 0);
    end

    // R7: result holds through idle cycles
    repeat (3) @(negedge clk);
    chk("R7 hold", 32'(res_data), 32'(VE[NV-1]));

    // R4: invalid cycles with live-looking strobes are ignored
    drive(1'b1, 1'b1, 1'b0, 16'd8, 4'd7);
    @(negedge clk);
    drive(1'b0, 1'b1, 1'b1, 16'd999, 4'd7);
    @(negedge clk);
    chk("R4 no done on invalid", 32'(res_valid), 0);
    @(negedge clk);
    chk("R7 hold while invalid", 32'(res_data), 32'(VE[NV-1]));
    drive(1'b1, 1'b0, 1'b1, 16'd4, 4'd7);
    @(negedge clk);
    idle();
    chk("R4 sum skips gaps", 32'(res_data), 12);

    // R3: start discards unfinished frame
    drive(1'b1, 1'b1, 1'b0, 16'd50, 4'd7);
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, 16'd50, 4'd7);
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b1, 16'd5, 4'd7);
    @(negedge clk);
    idle();
    chk("R3 restart", 32'(res_data), 5);

    // R5: back-to-back single-pair frames
    drive(1'b1, 1'b1, 1'b1, 16'd10, 4'd7);
    @(negedge clk);
    chk("R5 first done", 32'(res_valid), 1);
    chk("R5 first value", 32'(res_data), 10);
    drive(1'b1, 1'b1, 1'b1, 16'd20, 4'd7);
    @(negedge clk);
    idle();
    chk("R5 second done", 32'(res_valid), 1);
    chk("R5 second value", 32'(res_data), 20);
    @(negedge clk);
    chk("R5 pulse ends", 32'(res_valid), 0);

    // R8: reset in the middle of a frame
    drive(1'b1, 1'b1, 1'b0, 16'd77, 4'd7);
    @(negedge clk);
    rst_n = 1'b0;
    idle();
    @(negedge clk);
    chk("R8 mid-frame reset data", 32'(res_data), 0);
    chk("R8 mid-frame reset valid", 32'(res_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b1, 16'd3, 4'd14);  // -1/2 * 3 = -1.5 -> -2
    @(negedge clk);
    idle();
    chk("R2 after reset", 32'(res_data), 32'(16'hFFFE));

    @(negedge clk);
    finish_run();
  end
endmodule